// File: doc/BRIEF.md
# USART Control Byte Sequencer

This block is the processor-facing front end of a serial controller. It decodes chip select, read strobe, write strobe and the control/data select line. Each write to the control address is given a meaning by its place in a fixed order: first a mode byte, then as many SYNC characters as the mode calls for (none, one or two), then any number of command bytes. The block holds the mode, SYNC and command registers. It drives the modem handshake outputs from command bits and forms an eight-bit status word from transmitter, receiver and error flags.

The serial shifters sit outside this block. The block talks to them through plain levels and one-cycle strobes: a load strobe with a masked byte for the transmitter, a take strobe for the receiver, and pulse inputs for parity, overrun and framing errors. A hardware reset, or a command with the reset bit set, puts the block into standby. Standby drives every output to a quiet level and lasts until the next mode byte arrives.

Strobe actions occur on the system clock edge that first samples the write or read strobe high again after a low phase with chip select asserted.

Top module: `usart_ctrl_front`

## Requirements
- R1: After hardware reset `standby` is 1. The next control write (`cdSel`=1) is stored as the mode byte, which clears `standby`.
- R2: A mode byte with bits [1:0]=00 selects synchronous mode. Its bit 7 sets how many SYNC characters follow: 1 means one, 0 means two. That many following control writes go to `syncChar1` and then `syncChar2`, and they have no effect on the command outputs.
- R3: A mode byte with bits [1:0] other than 00 selects asynchronous mode. The next control write is then taken as a command, and `modeByte` shows the stored mode byte.
- R4: Command bit 0 drives `txEnable` and bit 2 drives `rxEnable`. Command bit 1 set to 1 drives `dtrN` low, and bit 5 set to 1 drives `rtsN` low. A 0 in either bit drives the matching output high.
- R5: While command bit 3 is set, `txdOut` is 0 whatever the value of `txSerIn`. Otherwise, outside standby, `txdOut` follows `txSerIn`.
- R6: A pulse on `parErrPulse`, `ovrErrPulse` or `frmErrPulse` sets a flag that stays set. A command with bit 4 set clears all three flags.
- R7: A command with bit 6 set returns the block to standby and clears the command register. The next control write is then a mode byte.
- R8: A command with bit 7 set produces a one-cycle `huntPulse`, but only when the stored mode is synchronous.
- R9: The status read (`cdSel`=1) returns these bits, from bit 0 upward: transmit buffer empty; receiver ready gated by receive enable; transmitter all empty; parity error; overrun; framing error; `syncBrkIn`; and the inverse of `dsrN`. A status read in standby returns 0.
- R10: `txRdyPin` is 1 only when `txBufEmpty` is 1, `ctsN` is 0 and transmit is enabled. Status bit 0 follows `txBufEmpty` alone.
- R11: The status value on `busOut` holds steady for as long as a status read stays active.
- R12: Mode bits [3:2] set the character length: 00 is 5 bits, 01 is 6, 10 is 7 and 11 is 8. A data read returns `rxByte` with the bits above that length forced to 0, and a completed data read pulses `rxTakeStb`. A data write in the command phase pulses `txLoadStb` and presents the masked byte on `txLoadByte`. Data writes in any other phase are ignored.
- R13: While `csN` is 1, `busOe` is 0 and reads and writes have no effect.
- R14: In standby, `txRdyPin`, `txEmpPin`, `rxRdyPin` and `syncBrkPin` are 0, and `txdOut`, `dtrN` and `rtsN` are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstHw | input | 1 | Asynchronous hardware reset, active high |
| csN | input | 1 | Chip select, active low |
| rdN | input | 1 | Read strobe, active low |
| wrN | input | 1 | Write strobe, active low |
| cdSel | input | 1 | 1 selects the control/status address, 0 selects data |
| busIn | input | 8 | Write data from the processor |
| busOut | output | 8 | Read data to the processor |
| busOe | output | 1 | Read data output enable |
| txBufEmpty | input | 1 | Transmit holding buffer is empty |
| txAllEmpty | input | 1 | Transmitter is fully empty |
| txSerIn | input | 1 | Serial bit from the transmit shifter |
| rxReady | input | 1 | Receiver holds an unread character |
| rxByte | input | 8 | Received character |
| parErrPulse | input | 1 | Parity error event |
| ovrErrPulse | input | 1 | Overrun event |
| frmErrPulse | input | 1 | Framing error event |
| syncBrkIn | input | 1 | SYNC found or break detected |
| ctsN | input | 1 | Clear to send, active low |
| dsrN | input | 1 | Data set ready, active low |
| standby | output | 1 | Waiting for a mode byte |
| modeByte | output | 8 | Stored mode byte |
| syncChar1 | output | 8 | First SYNC character |
| syncChar2 | output | 8 | Second SYNC character |
| txEnable | output | 1 | Transmit enable |
| rxEnable | output | 1 | Receive enable |
| huntPulse | output | 1 | Start hunt strobe |
| txLoadStb | output | 1 | Transmit character load strobe |
| txLoadByte | output | 8 | Masked transmit character |
| rxTakeStb | output | 1 | Received character taken strobe |
| txdOut | output | 1 | Serial line output |
| dtrN | output | 1 | Data terminal ready, active low |
| rtsN | output | 1 | Request to send, active low |
| txRdyPin | output | 1 | Transmitter ready request |
| txEmpPin | output | 1 | Transmitter empty |
| rxRdyPin | output | 1 | Receiver ready request |
| syncBrkPin | output | 1 | SYNC/break indication |

## Verification
Register writes take effect on the clock edge that first samples the write strobe high again. So `standby`, the mode, SYNC and command outputs, and `dtrN`/`rtsN`/`txdOut` change just after that edge, while `txLoadStb`, `huntPulse` and `rxTakeStb` are high for the single cycle after it. The status register takes its inputs one edge later, and an error flag needs two edges to show in status. For that reason the bench waits at least three cycles after any flag stimulus before it starts a status read. The behavioural model in the bench applies these same edge counts on every clock and is compared at each falling edge. The directed checks sample only once the stated latency has passed.

// File: rtl/usart_ctrl_pkg.sv
package usart_ctrl_pkg;
  localparam int BYTE_W = 8;
  localparam int LEN_W  = 2;

  // command bit positions
  localparam int CMD_TXEN = 0;
  localparam int CMD_DTR  = 1;
  localparam int CMD_RXEN = 2;
  localparam int CMD_BRK  = 3;
  localparam int CMD_ECLR = 4;
  localparam int CMD_RTS  = 5;
  localparam int CMD_SRST = 6;
  localparam int CMD_HUNT = 7;

  // mode byte fields
  localparam int MODE_LEN_LO = 2;
  localparam int MODE_ONE_SYNC = 7;

  // command bits that persist as levels
  localparam logic [BYTE_W-1:0] CMD_KEEP =
    (BYTE_W'(1) << CMD_TXEN) | (BYTE_W'(1) << CMD_DTR) | (BYTE_W'(1) << CMD_RXEN) |
    (BYTE_W'(1) << CMD_BRK)  | (BYTE_W'(1) << CMD_RTS);

  typedef enum logic [1:0] {
    SEQ_MODE  = 2'd0,
    SEQ_SYNC1 = 2'd1,
    SEQ_SYNC2 = 2'd2,
    SEQ_CMD   = 2'd3
  } seqState_t;

  typedef struct packed {
    logic              standby;
    logic              statHold;
    logic              modeWr;
    logic              sync1Wr;
    logic              sync2Wr;
    logic              cmdWr;
    logic              dataWr;
    logic              dataRd;
    logic [BYTE_W-1:0] wrByte;
  } ctrlStb_t;
endpackage

// File: rtl/usart_seq_ctrl.sv
module usart_seq_ctrl
  import usart_ctrl_pkg::*;
(
  input  logic              clk,
  input  logic              rstHw,
  input  logic              csN,
  input  logic              rdN,
  input  logic              wrN,
  input  logic              cdSel,
  input  logic [BYTE_W-1:0] busIn,
  input  logic              singleSync,
  output ctrlStb_t          stb
);
  seqState_t stQ, stD;
  logic wrActQ, wrCdQ, rdActQ, rdCdQ;
  logic [BYTE_W-1:0] wrByteQ;
  logic wrNow, rdNow, wrDone, rdDone;

  assign wrNow  = !csN && !wrN;
  assign rdNow  = !csN && !rdN;
  assign wrDone = wrActQ && !wrNow;
  assign rdDone = rdActQ && !rdNow;

  always_ff @(posedge clk or posedge rstHw) begin
    if (rstHw) begin
      stQ     <= SEQ_MODE;
      wrActQ  <= 1'b0;
      wrCdQ   <= 1'b0;
      wrByteQ <= '0;
      rdActQ  <= 1'b0;
      rdCdQ   <= 1'b0;
    end else begin
      stQ    <= stD;
      wrActQ <= wrNow;
      rdActQ <= rdNow;
      if (wrNow) begin
        wrCdQ   <= cdSel;
        wrByteQ <= busIn;
      end
      if (rdNow) rdCdQ <= cdSel;
    end
  end

  always_comb begin
    stb          = '0;
    stD          = stQ;
    stb.wrByte   = wrByteQ;
    stb.standby  = (stQ == SEQ_MODE);
    stb.statHold = rdNow && cdSel;
    stb.dataRd   = rdDone && !rdCdQ && (stQ != SEQ_MODE);
    if (wrDone) begin
      if (wrCdQ) begin
        unique case (stQ)
          SEQ_MODE: begin
            stb.modeWr = 1'b1;
            stD = (wrByteQ[1:0] == 2'b00) ? SEQ_SYNC1 : SEQ_CMD;
          end
          SEQ_SYNC1: begin
            stb.sync1Wr = 1'b1;
            stD = singleSync ? SEQ_CMD : SEQ_SYNC2;
          end
          SEQ_SYNC2: begin
            stb.sync2Wr = 1'b1;
            stD = SEQ_CMD;
          end
          SEQ_CMD: begin
            stb.cmdWr = 1'b1;
            if (wrByteQ[CMD_SRST]) stD = SEQ_MODE;
          end
          default: stD = SEQ_MODE;
        endcase
      end else if (stQ == SEQ_CMD) begin
        stb.dataWr = 1'b1;
      end
    end
  end
endmodule

// File: rtl/usart_ctrl_dp.sv
module usart_ctrl_dp
  import usart_ctrl_pkg::*;
(
  input  logic              clk,
  input  logic              rstHw,
  input  ctrlStb_t          stb,
  input  logic              csN,
  input  logic              rdN,
  input  logic              cdSel,
  input  logic              txBufEmpty,
  input  logic              txAllEmpty,
  input  logic              txSerIn,
  input  logic              rxReady,
  input  logic [BYTE_W-1:0] rxByte,
  input  logic              parErrPulse,
  input  logic              ovrErrPulse,
  input  logic              frmErrPulse,
  input  logic              syncBrkIn,
  input  logic              ctsN,
  input  logic              dsrN,
  output logic              singleSync,
  output logic [BYTE_W-1:0] busOut,
  output logic              busOe,
  output logic [BYTE_W-1:0] modeByte,
  output logic [BYTE_W-1:0] syncChar1,
  output logic [BYTE_W-1:0] syncChar2,
  output logic              txEnable,
  output logic              rxEnable,
  output logic              huntPulse,
  output logic              txLoadStb,
  output logic [BYTE_W-1:0] txLoadByte,
  output logic              rxTakeStb,
  output logic              txdOut,
  output logic              dtrN,
  output logic              rtsN,
  output logic              txRdyPin,
  output logic              txEmpPin,
  output logic              rxRdyPin,
  output logic              syncBrkPin
);
  localparam logic [LEN_W-1:0] LEN_MAX = '1;

  logic [BYTE_W-1:0] modeQ, sync1Q, sync2Q, cmdQ, statQ, loadByteQ, statNow, charMask;
  logic peQ, ovQ, feQ, loadQ, huntQ, takeQ, errClr, live;

  assign live     = !stb.standby;
  assign charMask = {BYTE_W{1'b1}} >> (LEN_MAX - modeQ[MODE_LEN_LO +: LEN_W]);
  assign errClr   = stb.cmdWr && (stb.wrByte[CMD_ECLR] || stb.wrByte[CMD_SRST]);

  assign txEnable = live && cmdQ[CMD_TXEN];
  assign rxEnable = live && cmdQ[CMD_RXEN];
  assign statNow  = {!dsrN, syncBrkIn, feQ, ovQ, peQ, txAllEmpty, rxReady && rxEnable, txBufEmpty};

  always_ff @(posedge clk or posedge rstHw) begin
    if (rstHw) begin
      modeQ <= '0; sync1Q <= '0; sync2Q <= '0; cmdQ <= '0; statQ <= '0;
      peQ <= 1'b0; ovQ <= 1'b0; feQ <= 1'b0;
      loadQ <= 1'b0; loadByteQ <= '0; huntQ <= 1'b0; takeQ <= 1'b0;
    end else begin
      if (stb.modeWr)  modeQ  <= stb.wrByte;
      if (stb.sync1Wr) sync1Q <= stb.wrByte;
      if (stb.sync2Wr) sync2Q <= stb.wrByte;
      if (stb.cmdWr)   cmdQ   <= stb.wrByte[CMD_SRST] ? '0 : (stb.wrByte & CMD_KEEP);
      if (errClr) begin
        peQ <= 1'b0; ovQ <= 1'b0; feQ <= 1'b0;
      end else begin
        peQ <= peQ || parErrPulse;
        ovQ <= ovQ || ovrErrPulse;
        feQ <= feQ || frmErrPulse;
      end
      if (stb.standby)       statQ <= '0;
      else if (!stb.statHold) statQ <= statNow;
      loadQ <= stb.dataWr;
      if (stb.dataWr) loadByteQ <= stb.wrByte & charMask;
      huntQ <= stb.cmdWr && stb.wrByte[CMD_HUNT] && !stb.wrByte[CMD_SRST] && (modeQ[1:0] == 2'b00);
      takeQ <= stb.dataRd;
    end
  end

  assign singleSync = modeQ[MODE_ONE_SYNC];
  assign busOe      = !csN && !rdN;
  assign busOut     = (!busOe || stb.standby) ? '0 : (cdSel ? statQ : (rxByte & charMask));
  assign modeByte   = modeQ;
  assign syncChar1  = sync1Q;
  assign syncChar2  = sync2Q;
  assign huntPulse  = huntQ;
  assign txLoadStb  = loadQ;
  assign txLoadByte = loadByteQ;
  assign rxTakeStb  = takeQ;
  assign txdOut     = stb.standby ? 1'b1 : (cmdQ[CMD_BRK] ? 1'b0 : txSerIn);
  assign dtrN       = !(live && cmdQ[CMD_DTR]);
  assign rtsN       = !(live && cmdQ[CMD_RTS]);
  assign txRdyPin   = txEnable && txBufEmpty && !ctsN;
  assign txEmpPin   = live && txAllEmpty;
  assign rxRdyPin   = rxEnable && rxReady;
  assign syncBrkPin = live && syncBrkIn;
endmodule

// File: rtl/usart_ctrl_front.sv
module usart_ctrl_front
  import usart_ctrl_pkg::*;
(
  input  logic              clk,
  input  logic              rstHw,
  input  logic              csN,
  input  logic              rdN,
  input  logic              wrN,
  input  logic              cdSel,
  input  logic [BYTE_W-1:0] busIn,
  output logic [BYTE_W-1:0] busOut,
  output logic              busOe,
  input  logic              txBufEmpty,
  input  logic              txAllEmpty,
  input  logic              txSerIn,
  input  logic              rxReady,
  input  logic [BYTE_W-1:0] rxByte,
  input  logic              parErrPulse,
  input  logic              ovrErrPulse,
  input  logic              frmErrPulse,
  input  logic              syncBrkIn,
  input  logic              ctsN,
  input  logic              dsrN,
  output logic              standby,
  output logic [BYTE_W-1:0] modeByte,
  output logic [BYTE_W-1:0] syncChar1,
  output logic [BYTE_W-1:0] syncChar2,
  output logic              txEnable,
  output logic              rxEnable,
  output logic              huntPulse,
  output logic              txLoadStb,
  output logic [BYTE_W-1:0] txLoadByte,
  output logic              rxTakeStb,
  output logic              txdOut,
  output logic              dtrN,
  output logic              rtsN,
  output logic              txRdyPin,
  output logic              txEmpPin,
  output logic              rxRdyPin,
  output logic              syncBrkPin
);
  ctrlStb_t stb;
  logic singleSync;

  usart_seq_ctrl ctrl_i (
    .clk(clk), .rstHw(rstHw), .csN(csN), .rdN(rdN), .wrN(wrN), .cdSel(cdSel),
    .busIn(busIn), .singleSync(singleSync), .stb(stb)
  );

  usart_ctrl_dp dp_i (
    .clk(clk), .rstHw(rstHw), .stb(stb), .csN(csN), .rdN(rdN), .cdSel(cdSel),
    .txBufEmpty(txBufEmpty), .txAllEmpty(txAllEmpty), .txSerIn(txSerIn),
    .rxReady(rxReady), .rxByte(rxByte), .parErrPulse(parErrPulse),
    .ovrErrPulse(ovrErrPulse), .frmErrPulse(frmErrPulse), .syncBrkIn(syncBrkIn),
    .ctsN(ctsN), .dsrN(dsrN), .singleSync(singleSync), .busOut(busOut), .busOe(busOe),
    .modeByte(modeByte), .syncChar1(syncChar1), .syncChar2(syncChar2),
    .txEnable(txEnable), .rxEnable(rxEnable), .huntPulse(huntPulse),
    .txLoadStb(txLoadStb), .txLoadByte(txLoadByte), .rxTakeStb(rxTakeStb),
    .txdOut(txdOut), .dtrN(dtrN), .rtsN(rtsN), .txRdyPin(txRdyPin),
    .txEmpPin(txEmpPin), .rxRdyPin(rxRdyPin), .syncBrkPin(syncBrkPin)
  );

  assign standby = stb.standby;
endmodule

// File: rtl/usart_ctrl_front_chk.sv
module usart_ctrl_front_chk (
  input logic       clk,
  input logic       rstHw,
  input logic       csN,
  input logic       rdN,
  input logic       cdSel,
  input logic [7:0] busOut,
  input logic       busOe,
  input logic       txBufEmpty,
  input logic       ctsN,
  input logic       standby,
  input logic [7:0] modeByte,
  input logic       txEnable,
  input logic       huntPulse,
  input logic       txLoadStb,
  input logic       txdOut,
  input logic       dtrN,
  input logic       rtsN,
  input logic       txRdyPin,
  input logic       txEmpPin,
  input logic       rxRdyPin,
  input logic       syncBrkPin
);
  // R14
  standby_quiet_chk: assert property (@(posedge clk) disable iff (rstHw)
    standby |-> (txdOut && dtrN && rtsN && !txRdyPin && !txEmpPin && !rxRdyPin && !syncBrkPin));

  // R10
  txrdy_gate_chk: assert property (@(posedge clk) disable iff (rstHw)
    txRdyPin |-> (txBufEmpty && !ctsN && txEnable));

  // R13
  cs_idle_chk: assert property (@(posedge clk) disable iff (rstHw)
    csN |-> !busOe);

  // R11
  stat_hold_chk: assert property (@(posedge clk) disable iff (rstHw)
    (!csN && !rdN && cdSel && !standby && $past(!csN && !rdN && cdSel && !standby)) |-> $stable(busOut));

  // R12
  len5_mask_chk: assert property (@(posedge clk) disable iff (rstHw)
    (busOe && !cdSel && modeByte[3:2] == 2'b00) |-> (busOut[7:5] == 3'b000));

  // R12
  load_live_chk: assert property (@(posedge clk) disable iff (rstHw)
    txLoadStb |-> !standby);

  // R8
  hunt_sync_chk: assert property (@(posedge clk) disable iff (rstHw)
    huntPulse |-> (modeByte[1:0] == 2'b00));

  // R8
  hunt_single_chk: assert property (@(posedge clk) disable iff (rstHw)
    huntPulse |=> !huntPulse);
endmodule

bind usart_ctrl_front usart_ctrl_front_chk chk_i (.*);

// File: tb/usart_ctrl_front_tb_top.sv
`timescale 1ns/1ps
module usart_ctrl_front_tb_top;
  logic clk = 1'b0;
  logic rstHw = 1'b1;
  logic csN = 1'b1, rdN = 1'b1, wrN = 1'b1, cdSel = 1'b0;
  logic [7:0] busIn = 8'h00;
  logic txBufEmpty = 1'b1, txAllEmpty = 1'b1, txSerIn = 1'b1, rxReady = 1'b0;
  logic [7:0] rxByte = 8'h00;
  logic parErrPulse = 1'b0, ovrErrPulse = 1'b0, frmErrPulse = 1'b0, syncBrkIn = 1'b0;
  logic ctsN = 1'b0, dsrN = 1'b1;
  logic [7:0] busOut, modeByte, syncChar1, syncChar2, txLoadByte;
  logic busOe, standby, txEnable, rxEnable, huntPulse, txLoadStb, rxTakeStb;
  logic txdOut, dtrN, rtsN, txRdyPin, txEmpPin, rxRdyPin, syncBrkPin;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  usart_ctrl_front dut_i (.*);

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  bit   mAwait, mWrPend, mWrCd, mRdPend, mRdCd, mPe, mOv, mFe, mLoad, mHunt, mTake;
  int   mSyncLeft, mSyncDone;
  byte unsigned mMode, mS1, mS2, mCmd, mStat, mLoadByte, mWrB;

  function automatic byte unsigned lenMask(byte unsigned md);
    int n = 5 + int'(md[3:2]);
    return byte'((1 << n) - 1);
  endfunction

  function automatic bit inCmdPhase();
    return !mAwait && mSyncLeft == 0;
  endfunction

  always @(posedge clk) begin
    bit wrNow, rdNow, clr;
    byte unsigned sv;
    if (rstHw) begin
      mAwait = 1; mWrPend = 0; mWrCd = 0; mRdPend = 0; mRdCd = 0;
      mPe = 0; mOv = 0; mFe = 0; mLoad = 0; mHunt = 0; mTake = 0;
      mSyncLeft = 0; mSyncDone = 0;
      mMode = 0; mS1 = 0; mS2 = 0; mCmd = 0; mStat = 0; mLoadByte = 0; mWrB = 0;
    end else begin
      wrNow = !csN && !wrN;
      rdNow = !csN && !rdN;
      sv = {~dsrN, syncBrkIn, mFe, mOv, mPe, txAllEmpty, rxReady & mCmd[2] & !mAwait, txBufEmpty};
      if (mAwait) mStat = 0;
      else if (!(rdNow && cdSel)) mStat = sv;
      mLoad = 0; mHunt = 0; mTake = 0; clr = 0;
      if (mRdPend && !rdNow && !mRdCd && !mAwait) mTake = 1;
      if (mWrPend && !wrNow) begin
        if (!mWrCd) begin
          if (inCmdPhase()) begin
            mLoad = 1;
            mLoadByte = mWrB & lenMask(mMode);
          end
        end else if (mAwait) begin
          mMode = mWrB; mAwait = 0; mSyncDone = 0;
          mSyncLeft = (mWrB[1:0] == 0) ? (mWrB[7] ? 1 : 2) : 0;
        end else if (mSyncLeft > 0) begin
          if (mSyncDone == 0) mS1 = mWrB; else mS2 = mWrB;
          mSyncDone++; mSyncLeft--;
        end else begin
          if (mWrB[6]) begin
            mAwait = 1; mCmd = 0; clr = 1;
          end else begin
            mCmd = mWrB & 8'h2F;
            if (mWrB[4]) clr = 1;
            if (mWrB[7] && mMode[1:0] == 0) mHunt = 1;
          end
        end
      end
      if (clr) begin mPe = 0; mOv = 0; mFe = 0; end
      else begin mPe |= parErrPulse; mOv |= ovrErrPulse; mFe |= frmErrPulse; end
      mWrPend = wrNow;
      if (wrNow) begin mWrCd = cdSel; mWrB = busIn; end
      mRdPend = rdNow;
      if (rdNow) mRdCd = cdSel;
    end
  end

  // per-clock comparison away from the active edge
  always @(negedge clk) begin
    if (!rstHw) begin
      bit oe, tx;
      byte unsigned expBus;
      oe = !csN && !rdN;
      tx = !mAwait && mCmd[0];
      expBus = (!oe || mAwait) ? 8'h00 : (cdSel ? mStat : (rxByte & lenMask(mMode)));
      chk("R1 standby", standby, mAwait);
      chk("R3 modeByte", modeByte, mMode);
      chk("R2 syncChar1", syncChar1, mS1);
      chk("R2 syncChar2", syncChar2, mS2);
      chk("R4 txEnable", txEnable, tx);
      chk("R4 rxEnable", rxEnable, mCmd[2]);
      chk("R4 dtrN", dtrN, !mCmd[1]);
      chk("R4 rtsN", rtsN, !mCmd[5]);
      chk("R5 txdOut", txdOut, mAwait ? 1 : (mCmd[3] ? 0 : txSerIn));
      chk("R8 huntPulse", huntPulse, mHunt);
      chk("R12 txLoadStb", txLoadStb, mLoad);
      chk("R12 txLoadByte", txLoadByte, mLoadByte);
      chk("R12 rxTakeStb", rxTakeStb, mTake);
      chk("R13 busOe", busOe, oe);
      chk("R9 busOut", busOut, expBus);
      chk("R10 txRdyPin", txRdyPin, tx && txBufEmpty && !ctsN);
      chk("R14 txEmpPin", txEmpPin, !mAwait && txAllEmpty);
      chk("R14 rxRdyPin", rxRdyPin, mCmd[2] && rxReady);
      chk("R14 syncBrkPin", syncBrkPin, !mAwait && syncBrkIn);
    end
  end

  // event catchers for directed checks
  bit sawHunt, sawLoad;
  always @(negedge clk) begin
    if (huntPulse) sawHunt = 1;
    if (txLoadStb) sawLoad = 1;
  end

  // ---------------- stimulus tasks ----------------
  task automatic busWrite(input bit cd, input byte unsigned b);
    @(posedge clk); #1 csN = 0; cdSel = cd; busIn = b; wrN = 0;
    repeat (2) @(posedge clk);
    #1 wrN = 1;
    @(posedge clk); #1 csN = 1;
    @(posedge clk); #1;
  endtask

  task automatic busRead(input bit cd, output byte unsigned v);
    @(posedge clk); #1 csN = 0; cdSel = cd; rdN = 0;
    @(negedge clk); v = busOut;
    @(posedge clk); #1 rdN = 1;
    @(posedge clk); #1 csN = 1;
    @(posedge clk); #1;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    byte unsigned v;
    repeat (3) @(posedge clk);
    #1 rstHw = 0;
    @(negedge clk);
    // R1 reset state, R14 quiet levels
    chk("R1 reset standby", standby, 1);
    chk("R14 reset dtrN", dtrN, 1);
    chk("R14 reset txdOut", txdOut, 1);
    chk("R14 reset txRdyPin", txRdyPin, 0);

    // R3 async x16, 8 bits, no parity
    busWrite(1, 8'h4E);
    @(negedge clk);
    chk("R1 mode ends standby", standby, 0);
    chk("R3 mode stored", modeByte, 8'h4E);
    busWrite(1, 8'h27);
    @(negedge clk);
    chk("R4 txEnable", txEnable, 1);
    chk("R4 rxEnable", rxEnable, 1);
    chk("R4 dtrN low", dtrN, 0);
    chk("R4 rtsN low", rtsN, 0);
    chk("R10 txRdyPin set", txRdyPin, 1);

    // R10 CTS high masks pin but not status bit 0
    ctsN = 1; idle(3);
    @(negedge clk);
    chk("R10 txRdyPin masked", txRdyPin, 0);
    busRead(1, v);
    chk("R9 R10 status async", v, 8'h05);

    // R9 DSR inverted, receiver ready
    dsrN = 0; rxReady = 1; idle(3);
    busRead(1, v);
    chk("R9 status dsr rx", v, 8'h87);

    // R6 sticky error flags
    @(posedge clk); #1 parErrPulse = 1; frmErrPulse = 1;
    @(posedge clk); #1 parErrPulse = 0; frmErrPulse = 0;
    idle(3);
    busRead(1, v);
    chk("R6 flags set", v, 8'hAF);
    busWrite(1, 8'h37);
    idle(2);
    busRead(1, v);
    chk("R6 flags cleared", v, 8'h87);

    // R11 status held while read active
    @(posedge clk); #1 csN = 0; cdSel = 1; rdN = 0;
    @(posedge clk); #1 rxReady = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R11 held value", busOut, 8'h87);
    @(posedge clk); #1 rdN = 1;
    @(posedge clk); #1 csN = 1;
    idle(2);
    busRead(1, v);
    chk("R11 updated after read", v, 8'h85);

    // R12 8-bit data read and write
    rxByte = 8'hFF;
    busRead(0, v);
    chk("R12 8-bit read", v, 8'hFF);
    sawLoad = 0;
    busWrite(0, 8'hA5);
    chk("R12 load strobe", sawLoad, 1);
    chk("R12 load byte", txLoadByte, 8'hA5);

    // R5 break
    busWrite(1, 8'h2F);
    @(negedge clk);
    chk("R5 break line low", txdOut, 0);

    // R7 soft reset
    busWrite(1, 8'h40);
    @(negedge clk);
    chk("R7 standby again", standby, 1);
    chk("R14 dtrN high", dtrN, 1);
    chk("R14 txdOut high", txdOut, 1);

    // R2 sync mode with two SYNC characters, 5-bit
    busWrite(1, 8'h00);
    busWrite(1, 8'h16);
    busWrite(1, 8'h26);
    @(negedge clk);
    chk("R2 sync1", syncChar1, 8'h16);
    chk("R2 sync2", syncChar2, 8'h26);
    chk("R2 no command yet", dtrN, 1);
    sawHunt = 0;
    busWrite(1, 8'h86);
    chk("R8 hunt in sync", sawHunt, 1);
    chk("R4 dtr after sync", dtrN, 0);
    busRead(0, v);
    chk("R12 5-bit read", v, 8'h1F);
    busWrite(0, 8'hFF);
    chk("R12 5-bit load", txLoadByte, 8'h1F);

    // R8 no hunt in async
    busWrite(1, 8'h40);
    busWrite(1, 8'h4D);
    sawHunt = 0;
    busWrite(1, 8'h80);
    chk("R8 no hunt async", sawHunt, 0);

    // R2 single SYNC character
    busWrite(1, 8'h40);
    busWrite(1, 8'h80);
    busWrite(1, 8'h55);
    busWrite(1, 8'h02);
    @(negedge clk);
    chk("R2 single sync stored", syncChar1, 8'h55);
    chk("R2 command after one sync", dtrN, 0);

    // R13 chip select high ignores strobes
    @(posedge clk); #1 csN = 1; cdSel = 1; busIn = 8'h20; wrN = 0; rdN = 0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R13 no output enable", busOe, 0);
    @(posedge clk); #1 wrN = 1; rdN = 1;
    idle(2);
    @(negedge clk);
    chk("R13 write ignored", rtsN, 1);

    idle(2);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule